// File: doc/BRIEF.md
# Page-Mode Asynchronous ROM Reader

This block sits between an internal requester and an external read-only memory that has no clock. The memory answers a random read after a long settle time. After that, any other entry in the same eight-entry page answers after a much shorter time, as long as the chip select and the page bits stay unchanged. The reader accepts one request at a time through a valid/ready handshake. Each request carries a 22-bit byte address and a flag that selects byte or word width. The reader drives the memory's address, chip-enable, output-enable and width-select pins from registers. It holds them for a fixed number of clock cycles and then captures the data lines into a one-cycle response.

The reader keeps the memory selected only while requests arrive back to back. A request accepted in the single cycle after a response is a page hit when it uses the same width and the same page. A hit waits the short page count, and any other address in the same width waits the full random count. A width change, or a cycle with no request after a response, closes the memory. Closing deasserts both enables, forgets the open page and waits out the memory's output turn-off time. In byte width, the top data line turns around and becomes the lowest address input, driven by the reader.

Top module: `prp_reader`

## Requirements
- R1: While reset is high and after it, before any request, mem_ce_n and mem_oe_n are 1, mem_q15_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request accepted while the memory is closed produces rsp_valid exactly RAND_WAIT cycles after the accepting clock edge, where RAND_WAIT is the larger of T_RAND and T_OE, with zero read as one.
- R3: A request accepted in the cycle right after a response is a page hit when it uses the same width and byte address bits 21..4 equal those of the previous request. A page hit responds PAGE_WAIT = max(T_PAGE,1) cycles after acceptance, with mem_ce_n held low.
- R4: A same-width request to a different page accepted in the cycle after a response keeps mem_ce_n low and responds RAND_WAIT cycles after acceptance.
- R5: In word width (req_byte = 0), mem_wsel is 1, mem_addr equals req_addr[21:1], mem_q15_oe is 0 and rsp_data carries all 16 data lines.
- R6: In byte width (req_byte = 1), mem_wsel is 0, mem_addr equals req_addr[21:1], mem_q15_oe is 1 with mem_q15_out equal to req_addr[0], and rsp_data holds data lines 7..0 with bits 15..8 zero.
- R7: A request of the other width accepted in the cycle after a response first holds mem_ce_n and mem_oe_n high for DIS_WAIT = max(T_DIS,1) cycles. It then starts a full random access, so it responds DIS_WAIT + RAND_WAIT cycles after acceptance. The top data line is never driven by the reader within DIS_WAIT cycles of the memory driving it in word width.
- R8: If no request is presented in the cycle after a response, both enables return high within one cycle. The next request waits the full random time.
- R9: rsp_valid is a one-cycle pulse, and req_ready is high only when the memory is closed and idle, or in the single cycle after a response.
- R10: While an access is counting, mem_addr, mem_wsel, mem_q15_out and mem_ce_n hold steady up to and including the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Byte address of the read |
| req_byte | input | 1 | 1 selects byte width, 0 word width |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Read data, upper byte zero in byte width |
| mem_addr | output | 21 | Memory address pins, word granularity |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_wsel | output | 1 | Width select: 1 word, 0 byte |
| mem_q_in | input | 16 | Memory data lines as seen by the reader |
| mem_q15_out | output | 1 | Value driven onto the top data line in byte width |
| mem_q15_oe | output | 1 | Enable for driving the top data line |

## Verification
The hardest state to reach is a request of the other width arriving in the one cycle after a response. That is the only path that forces a close-and-reopen while a request is already pending. The bench reaches it by presenting the next request before the current one finishes, so it is taken on the ready cycle. A bench memory model ages every pin group since its last change and returns corrupted data on an early capture, so any shortened wait shows up as a data mismatch. A seeded stream with random widths, two pages and random gaps mixes hits, misses, width changes and closes.

// File: rtl/prp_pkg.sv
package prp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_NEXT  = 2'd2,
    ST_CLOSE = 2'd3
  } prp_state_e;

  function automatic int unsigned floor_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prp_wait_timer.sv
module prp_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R2: a running wait counts down by one each cycle
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prp_page_track.sv
module prp_page_track #(
  parameter int KEY_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [KEY_W-1:0] load_key,
  input  logic             load_byte,
  input  logic [KEY_W-1:0] cmp_key,
  input  logic             cmp_byte,
  output logic             hit
);

  logic [KEY_W-1:0] key_q;
  logic             byte_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      byte_q <= 1'b0;
      open_q <= 1'b0;
    end else if (clear) begin
      open_q <= 1'b0;
    end else if (load) begin
      key_q  <= load_key;
      byte_q <= load_byte;
      open_q <= 1'b1;
    end
  end

  assign hit = open_q && (key_q == cmp_key) && (byte_q == cmp_byte);

  // R8: closing the memory forgets the open page
  a_r8_forget: assert property (@(posedge clk) disable iff (rst)
    clear |=> !hit);

endmodule

// File: rtl/prp_pin_map.sv
module prp_pin_map #(
  parameter int BYTE_AW = 22,
  parameter int DW      = 16,
  parameter int PAGE_W  = 3
) (
  input  logic [BYTE_AW-1:0]          byte_addr,
  input  logic                        byte_mode,
  output logic [BYTE_AW-2:0]          word_addr,
  output logic [BYTE_AW-2-PAGE_W:0]   page_key,
  output logic                        lsb_bit,
  input  logic [DW-1:0]               q_in,
  input  logic                        q_byte_mode,
  output logic [DW-1:0]               rsp_word
);

  localparam int HALF = DW / 2;

  assign word_addr = byte_addr[BYTE_AW-1:1];
  assign page_key  = byte_addr[BYTE_AW-1:PAGE_W+1];
  assign lsb_bit   = byte_mode & byte_addr[0];

  for (genvar i = 0; i < DW; i++) begin : g_lane
    if (i < HALF) begin : g_low
      assign rsp_word[i] = q_in[i];
    end else begin : g_high
      assign rsp_word[i] = q_byte_mode ? 1'b0 : q_in[i];
    end
  end

endmodule

// File: rtl/prp_reader.sv
module prp_reader #(
  parameter int BYTE_AW = 22,
  parameter int DW      = 16,
  parameter int PAGE_W  = 3,
  parameter int T_RAND  = 8,
  parameter int T_PAGE  = 3,
  parameter int T_OE    = 3,
  parameter int T_DIS   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BYTE_AW-1:0] req_addr,
  input  logic               req_byte,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic [BYTE_AW-2:0] mem_addr,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_wsel,
  input  logic [DW-1:0]      mem_q_in,
  output logic               mem_q15_out,
  output logic               mem_q15_oe
);
  import prp_pkg::*;

  localparam int WORD_AW   = BYTE_AW - 1;
  localparam int KEY_W     = WORD_AW - PAGE_W;
  localparam int RAND_WAIT = max2(floor_one(T_RAND), floor_one(T_OE));
  localparam int PAGE_WAIT = floor_one(T_PAGE);
  localparam int DIS_WAIT  = floor_one(T_DIS);
  localparam int MAX_WAIT  = max2(RAND_WAIT, max2(PAGE_WAIT, DIS_WAIT));
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] RAND_LD = CNT_W'(RAND_WAIT - 1);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_WAIT - 1);
  localparam logic [CNT_W-1:0] DIS_LD  = CNT_W'(DIS_WAIT - 1);

  prp_state_e st_q, st_d;

  logic [BYTE_AW-1:0] pend_addr_q;
  logic               pend_byte_q;
  logic               pend_go_q, pend_go_d;
  logic               wsel_q;

  logic [BYTE_AW-1:0] src_addr;
  logic               src_byte;
  logic [WORD_AW-1:0] map_word;
  logic [KEY_W-1:0]   map_key;
  logic               map_lsb;
  logic [DW-1:0]      map_rsp;

  logic               accept;
  logic               same_mode;
  logic               drive_pins, full_open, go_close, capture, pend_ld;
  logic               trk_clear, trk_load, trk_hit;
  logic               tmr_load, tmr_done;
  logic [CNT_W-1:0]   tmr_val;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_NEXT);
  assign accept    = req_valid && req_ready;
  assign same_mode = (req_byte == ~wsel_q);
  assign src_addr  = (st_q == ST_CLOSE) ? pend_addr_q : req_addr;
  assign src_byte  = (st_q == ST_CLOSE) ? pend_byte_q : req_byte;
  assign mem_wsel  = wsel_q;

  prp_pin_map #(.BYTE_AW(BYTE_AW), .DW(DW), .PAGE_W(PAGE_W)) u_map (
    .byte_addr   (src_addr),
    .byte_mode   (src_byte),
    .word_addr   (map_word),
    .page_key    (map_key),
    .lsb_bit     (map_lsb),
    .q_in        (mem_q_in),
    .q_byte_mode (~wsel_q),
    .rsp_word    (map_rsp)
  );

  prp_page_track #(.KEY_W(KEY_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .clear     (trk_clear),
    .load      (trk_load),
    .load_key  (map_key),
    .load_byte (src_byte),
    .cmp_key   (map_key),
    .cmp_byte  (src_byte),
    .hit       (trk_hit)
  );

  prp_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    st_d       = st_q;
    pend_go_d  = pend_go_q;
    drive_pins = 1'b0;
    full_open  = 1'b0;
    go_close   = 1'b0;
    capture    = 1'b0;
    pend_ld    = 1'b0;
    trk_clear  = 1'b0;
    trk_load   = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          drive_pins = 1'b1;
          full_open  = 1'b1;
          trk_load   = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = RAND_LD;
          st_d       = ST_ACC;
        end
      end
      ST_ACC: begin
        if (tmr_done) begin
          capture = 1'b1;
          st_d    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (accept && same_mode) begin
          drive_pins = 1'b1;
          trk_load   = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = trk_hit ? PAGE_LD : RAND_LD;
          st_d       = ST_ACC;
        end else begin
          go_close  = 1'b1;
          trk_clear = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = DIS_LD;
          pend_ld   = accept;
          pend_go_d = accept;
          st_d      = ST_CLOSE;
        end
      end
      default: begin
        if (tmr_done) begin
          if (pend_go_q) begin
            drive_pins = 1'b1;
            full_open  = 1'b1;
            trk_load   = 1'b1;
            tmr_load   = 1'b1;
            tmr_val    = RAND_LD;
            pend_go_d  = 1'b0;
            st_d       = ST_ACC;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      pend_addr_q <= '0;
      pend_byte_q <= 1'b0;
      pend_go_q   <= 1'b0;
      mem_addr    <= '0;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      wsel_q      <= 1'b1;
      mem_q15_out <= 1'b0;
      mem_q15_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      st_q      <= st_d;
      pend_go_q <= pend_go_d;
      rsp_valid <= capture;
      if (capture) begin
        rsp_data <= map_rsp;
      end
      if (pend_ld) begin
        pend_addr_q <= req_addr;
        pend_byte_q <= req_byte;
      end
      if (drive_pins) begin
        mem_addr    <= map_word;
        mem_q15_out <= map_lsb;
      end
      if (full_open) begin
        mem_ce_n   <= 1'b0;
        mem_oe_n   <= 1'b0;
        wsel_q     <= ~src_byte;
        mem_q15_oe <= src_byte;
      end else if (go_close) begin
        mem_ce_n   <= 1'b1;
        mem_oe_n   <= 1'b1;
        mem_q15_oe <= 1'b0;
      end
    end
  end

  // R9: the response strobe lasts one cycle
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10: pins hold while an access is still counting
  a_r10_pins_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACC && !tmr_done) |=>
      ($stable(mem_addr) && $stable(mem_wsel) && $stable(mem_q15_out) && !mem_ce_n));

  // R6: the top data line is driven only in byte width
  a_r6_q15_byte_only: assert property (@(posedge clk) disable iff (rst)
    mem_q15_oe |-> !mem_wsel);

  // R7: during the turn-off wait the memory is fully deselected
  a_r7_close_off: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CLOSE) |-> (mem_ce_n && mem_oe_n && !mem_q15_oe));

  // R8: no follow-on request releases the memory
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NEXT && !req_valid) |=> (mem_ce_n && mem_oe_n));

  // R1: reset leaves the memory deselected
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (mem_ce_n && mem_oe_n && !mem_q15_oe && !rsp_valid));

endmodule

// File: tb/prp_reader_test.sv
module prp_reader_test;

  localparam int RW = 8;
  localparam int PW = 3;
  localparam int DWT = 2;
  localparam int OEW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_wsel;
  logic [15:0] mem_q_in = 16'hFFFF;
  logic        mem_q15_out, mem_q15_oe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  prp_reader #(.T_RAND(RW), .T_PAGE(PW), .T_OE(OEW), .T_DIS(DWT)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_wsel(mem_wsel), .mem_q_in(mem_q_in),
    .mem_q15_out(mem_q15_out), .mem_q15_oe(mem_q15_oe)
  );

  function automatic logic [15:0] wd(input logic [20:0] w);
    return w[15:0] ^ w[20:5] ^ 16'h3C5A;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ages of each pin group, garbage on an early capture
  int rand_age = 0, page_age = 0, oe_age = 0, rel_age = 100;
  logic        p_ce_n = 1'b1, p_oe_n = 1'b1, p_wsel = 1'b1, p_q15 = 1'b0;
  logic [20:0] p_addr = '0;

  always @(negedge clk) begin
    logic ok;
    logic [15:0] w;
    if (mem_ce_n) rand_age = 0;
    else if (p_ce_n || mem_addr[20:3] != p_addr[20:3] || mem_wsel != p_wsel) rand_age = 1;
    else if (rand_age < 1000) rand_age++;
    if (mem_addr[2:0] != p_addr[2:0] || (!mem_wsel && mem_q15_out != p_q15)) page_age = 1;
    else if (page_age < 1000) page_age++;
    if (mem_oe_n) oe_age = 0;
    else if (p_oe_n) oe_age = 1;
    else if (oe_age < 1000) oe_age++;
    if (!mem_ce_n && !mem_oe_n && mem_wsel) rel_age = 0;
    else if (rel_age < 1000) rel_age++;
    if (mem_q15_oe && rel_age <= DWT) begin
      total++; bad++;
      $display("FAIL R7 top line driven too early actual=%0d expected>%0d", rel_age, DWT);
    end
    p_ce_n = mem_ce_n; p_oe_n = mem_oe_n; p_wsel = mem_wsel;
    p_q15 = mem_q15_out; p_addr = mem_addr;
    ok = !mem_ce_n && !mem_oe_n && rand_age >= RW && page_age >= PW && oe_age >= OEW;
    w = wd(mem_addr);
    if (mem_wsel) mem_q_in = ok ? w : 16'hBAD1;
    else mem_q_in = {1'b1, 7'h25, ok ? (mem_q15_out ? w[15:8] : w[7:0]) : 8'h5A};
  end

  // bench view of the open page
  logic        open_b = 1'b0;
  logic        pm_b = 1'b0;
  logic [17:0] pp_b = '0;

  task automatic send(input logic [21:0] a, input logic bm);
    int lat, cehi, rdy, exp_lat, exp_ce;
    logic [15:0] ed;
    logic [15:0] w;
    if (!open_b) begin exp_lat = RW; exp_ce = 0; end
    else if (bm != pm_b) begin exp_lat = DWT + RW; exp_ce = DWT; end
    else if (a[21:4] == pp_b) begin exp_lat = PW; exp_ce = 0; end
    else begin exp_lat = RW; exp_ce = 0; end
    w = wd(a[21:1]);
    ed = bm ? {8'h00, a[0] ? w[15:8] : w[7:0]} : w;
    req_addr = a; req_byte = bm; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid, "R9 strobe drops after one cycle", rsp_valid, 0);
    lat = 0; cehi = 0; rdy = 0;
    while (!rsp_valid) begin
      if (mem_ce_n) cehi++;
      if (req_ready) rdy++;
      lat++;
      @(negedge clk);
    end
    if (exp_ce == DWT)
      chk(lat == exp_lat, "R7 latency after width change", lat, exp_lat);
    else if (exp_lat == PW)
      chk(lat == exp_lat, "R3 page hit latency", lat, exp_lat);
    else if (open_b)
      chk(lat == exp_lat, "R4 page miss latency", lat, exp_lat);
    else
      chk(lat == exp_lat, "R2 closed start latency", lat, exp_lat);
    chk(cehi == exp_ce, "R7 deselect cycles", cehi, exp_ce);
    chk(rdy == 0 && req_ready, "R9 ready only in idle or after response", rdy, 0);
    chk(rsp_data == ed, bm ? "R6 byte data" : "R5 word data", rsp_data, ed);
    chk(mem_addr == a[21:1] && mem_wsel == !bm && mem_q15_oe == bm &&
        (!bm || mem_q15_out == a[0]),
        "R10 pins held through capture", mem_addr, a[21:1]);
    open_b = 1'b1; pm_b = bm; pp_b = a[21:4];
  endtask

  task automatic gap(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
    open_b = 1'b0;
    if (n >= DWT + 1)
      chk(mem_ce_n && mem_oe_n && !mem_q15_oe && req_ready, "R8 released after idle cycle",
          {mem_ce_n, mem_oe_n}, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned lf;
    logic [17:0] pages [2];
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && !mem_q15_oe && !rsp_valid, "R1 state in reset",
        {mem_ce_n, mem_oe_n, mem_q15_oe, rsp_valid}, 12);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && !mem_q15_oe && !rsp_valid && req_ready,
        "R1 state after reset", {mem_ce_n, mem_oe_n, req_ready}, 7);

    // word width: full sweep of one page, then a new page
    for (int off = 0; off < 8; off++) send({18'h2A5C3, off[2:0], 1'b0}, 1'b0);
    send({18'h01234, 3'd5, 1'b0}, 1'b0);
    // width change onto the same page, then all sixteen bytes
    for (int off = 0; off < 16; off++) send({18'h01234, off[3:0]}, 1'b1);
    gap(DWT + 2);
    send({18'h01234, 4'd9}, 1'b1);
    send({18'h3FFFF, 4'd15}, 1'b1);
    send({18'h3FFFF, 4'd0}, 1'b0);
    gap(1);
    send({18'h00000, 4'd0}, 1'b0);

    // seeded stream over two pages with random widths and gaps
    pages[0] = 18'h15555; pages[1] = 18'h2AAAA;
    lf = 32'h1F2E3D4C;
    for (int i = 0; i < 120; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      send({pages[lf[20]], lf[27:24]}, lf[29] & lf[30]);
      if (lf[16:14] == 3'd0) gap(1 + int'(lf[19:18]) + DWT);
    end

    gap(DWT + 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule